// File: doc/BRIEF.md
# Segmented Key Vector Lookup Filter

This block screens join keys against a compact table of dense grouping keys kept in on-chip byte storage. Every beat presents four 32-bit join keys. For each of them the block takes the upper key bits as a segment number and the lower bits as an entry number within that segment. It finds the byte that holds the entry, pulls out an entry of the currently selected width (1, 2, 4, 8 or 32 bits) and returns that value as the lane's dense key. A lane passes when its dense key is nonzero. A dense key of zero means the join key has no partner and is dropped.

The table is filled one byte at a time through a write port before or between probe streams. Segment size and segment count are build-time parameters. The entry width is chosen per beat. One beat can be accepted every cycle, and each beat's results appear exactly two cycles after it is accepted.

Top module: `kv_filter`

## Requirements
- R1: A beat accepted with `in_valid_i` high at a clock edge yields `out_valid_o` high for exactly one cycle, two edges later. `out_valid_o` is never high without such a beat. Beats may arrive back to back.
- R2: Width code 0 selects 1-bit entries. With the default 16-byte segments, the entry number is key[6:0] and the segment is key>>7. The byte is segment*16 + entry/8, and the bit within it is entry mod 8.
- R3: Width code 1 selects 2-bit entries. The entry number is key[5:0] and the segment is key>>6. The byte is entry/4, and the field starts at bit 2*(entry mod 4).
- R4: Width code 2 selects 4-bit entries. The entry number is key[4:0] and the segment is key>>5. The byte is entry>>1. Entry bit 0 equal to 0 selects bits 3:0 of the byte, and 1 selects bits 7:4.
- R5: Width code 3 selects 8-bit entries. The entry number is key[3:0] and the segment is key>>4. The whole byte is returned.
- R6: Width code 4 selects 32-bit entries. The entry number is key[1:0] and the segment is key>>2. Four bytes starting at entry*4 are read and combined little-endian (the lowest address is bits 7:0).
- R7: A key whose segment number is not below the segment count (8 by default) returns dense key 0 and a clear pass bit.
- R8: A lane's pass bit is set exactly when its returned dense key is nonzero.
- R9: Width codes 5, 6 and 7 return dense key 0 and a clear pass bit on every lane.
- R10: A byte written through the write port at a clock edge (byte address = segment*16 + byte in segment) is seen by every beat accepted at that edge or later.
- R11: Reset clears the whole table and the output valid, so lookups right after reset return 0 on every lane.
- R12: While `out_valid_o` is low, `out_dense_o` and `out_pass_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width_i | input | 3 | Entry width code for the beat (0:1b, 1:2b, 2:4b, 3:8b, 4:32b) |
| in_valid_i | input | 1 | Beat present |
| in_keys_i | input | 128 | Four join keys, lane n in bits 32n+31:32n |
| wr_en_i | input | 1 | Table byte write enable |
| wr_addr_i | input | 7 | Table byte address |
| wr_data_i | input | 8 | Table byte data |
| out_valid_o | output | 1 | Results present |
| out_dense_o | output | 128 | Dense key per lane, lane n in bits 32n+31:32n |
| out_pass_o | output | 4 | Pass bit per lane |

## Verification
The table is filled with a byte pattern in which neighbouring bytes differ. Probes then run in every width, and within each width the entry numbers are chosen to reach the first and last byte of a segment, both nibble halves of one byte, and every bit offset class. A wrong shift amount, a swapped half or a byte-order slip therefore returns a visibly different value. Keys just beyond the last segment and all-ones keys separate range rejection from address wrap. Reserved width codes and deliberately zeroed bytes separate the pass logic from the extraction. Back-to-back beats, gaps and a write landing on the same edge as a probe expose latency and write-visibility errors.

// File: rtl/kv_pkg.sv
package kv_pkg;
    typedef enum logic [2:0] {
        KV_W1  = 3'd0,
        KV_W2  = 3'd1,
        KV_W4  = 3'd2,
        KV_W8  = 3'd3,
        KV_W32 = 3'd4
    } kv_width_e;
endpackage

// File: rtl/kv_index.sv
module kv_index
    import kv_pkg::*;
#(
    parameter int KEY_W    = 32,
    parameter int SEG_AW   = 4,
    parameter int SEG_IW   = 3,
    parameter int NUM_SEGS = 8,
    parameter int ADDR_W   = 7
) (
    input  logic [KEY_W-1:0]  key_i,
    input  logic [2:0]        width_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [2:0]        off_o,
    output logic              ok_o
);
    logic [5:0]        sh;
    logic              known;
    logic [KEY_W-1:0]  entry;
    logic [KEY_W-1:0]  seg_full;
    logic [SEG_AW-1:0] byte_sel;

    always_comb begin
        known = 1'b1;
        case (width_i)
            KV_W1:   sh = 6'(SEG_AW + 3);
            KV_W2:   sh = 6'(SEG_AW + 2);
            KV_W4:   sh = 6'(SEG_AW + 1);
            KV_W8:   sh = 6'(SEG_AW);
            KV_W32:  sh = 6'(SEG_AW - 2);
            default: begin sh = 6'(SEG_AW); known = 1'b0; end
        endcase
        entry    = key_i & ~({KEY_W{1'b1}} << sh);
        seg_full = key_i >> sh;
        case (width_i)
            KV_W1:   begin byte_sel = SEG_AW'(entry >> 3); off_o = entry[2:0];          end
            KV_W2:   begin byte_sel = SEG_AW'(entry >> 2); off_o = {entry[1:0], 1'b0};  end
            KV_W4:   begin byte_sel = SEG_AW'(entry >> 1); off_o = {entry[0], 2'b00};   end
            KV_W32:  begin byte_sel = SEG_AW'(entry << 2); off_o = 3'd0;                end
            default: begin byte_sel = SEG_AW'(entry);      off_o = 3'd0;                end
        endcase
        addr_o = {seg_full[SEG_IW-1:0], byte_sel};
        ok_o   = known && (seg_full < KEY_W'(NUM_SEGS));
    end
endmodule

// File: rtl/kv_extract.sv
module kv_extract
    import kv_pkg::*;
#(
    parameter int KEY_W = 32
) (
    input  logic [31:0]      bytes_i,
    input  logic [2:0]       width_i,
    input  logic [2:0]       off_i,
    input  logic             ok_i,
    output logic [KEY_W-1:0] dense_o
);
    logic [7:0] shifted;

    always_comb begin
        shifted = bytes_i[7:0] >> off_i;
        case (width_i)
            KV_W1:   dense_o = KEY_W'(shifted[0]);
            KV_W2:   dense_o = KEY_W'(shifted[1:0]);
            KV_W4:   dense_o = KEY_W'(shifted[3:0]);
            KV_W8:   dense_o = KEY_W'(bytes_i[7:0]);
            KV_W32:  dense_o = KEY_W'(bytes_i);
            default: dense_o = '0;
        endcase
        if (!ok_i) begin
            dense_o = '0;
        end
    end
endmodule

// File: rtl/kv_filter.sv
module kv_filter
    import kv_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int KEY_W     = 32,
    parameter int SEG_BYTES = 16,
    parameter int NUM_SEGS  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               cfg_width_i,
    input  logic                     in_valid_i,
    input  logic [LANES*KEY_W-1:0]   in_keys_i,
    input  logic                     wr_en_i,
    input  logic [$clog2(SEG_BYTES*NUM_SEGS)-1:0] wr_addr_i,
    input  logic [7:0]               wr_data_i,
    output logic                     out_valid_o,
    output logic [LANES*KEY_W-1:0]   out_dense_o,
    output logic [LANES-1:0]         out_pass_o
);
    localparam int SEG_AW    = $clog2(SEG_BYTES);
    localparam int SEG_IW    = $clog2(NUM_SEGS);
    localparam int MEM_BYTES = SEG_BYTES * NUM_SEGS;
    localparam int ADDR_W    = $clog2(MEM_BYTES);

    typedef struct packed {
        logic              ok;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        off;
    } lane_req_t;

    typedef struct packed {
        logic                         s1_valid;
        logic [2:0]                   s1_width;
        lane_req_t [LANES-1:0]        s1_req;
        logic                         s2_valid;
        logic [LANES-1:0][KEY_W-1:0]  s2_dense;
        logic [LANES-1:0]             s2_pass;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [7:0]        mem_q [MEM_BYTES];
    logic [ADDR_W-1:0] idx_addr  [LANES];
    logic [2:0]        idx_off   [LANES];
    logic              idx_ok    [LANES];
    logic [31:0]       rd_bytes  [LANES];
    logic [KEY_W-1:0]  ext_dense [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ADDR_W-1:0] base;

        kv_index #(
            .KEY_W    (KEY_W),
            .SEG_AW   (SEG_AW),
            .SEG_IW   (SEG_IW),
            .NUM_SEGS (NUM_SEGS),
            .ADDR_W   (ADDR_W)
        ) u_idx (
            .key_i   (in_keys_i[l*KEY_W +: KEY_W]),
            .width_i (cfg_width_i),
            .addr_o  (idx_addr[l]),
            .off_o   (idx_off[l]),
            .ok_o    (idx_ok[l])
        );

        assign base        = pipe_q.s1_req[l].addr;
        assign rd_bytes[l] = {mem_q[base + ADDR_W'(3)], mem_q[base + ADDR_W'(2)],
                              mem_q[base + ADDR_W'(1)], mem_q[base]};

        kv_extract #(
            .KEY_W (KEY_W)
        ) u_ext (
            .bytes_i (rd_bytes[l]),
            .width_i (pipe_q.s1_width),
            .off_i   (pipe_q.s1_req[l].off),
            .ok_i    (pipe_q.s1_req[l].ok),
            .dense_o (ext_dense[l])
        );
    end

    always_comb begin
        pipe_d          = pipe_q;
        pipe_d.s1_valid = in_valid_i;
        pipe_d.s1_width = cfg_width_i;
        for (int l = 0; l < LANES; l++) begin
            pipe_d.s1_req[l].ok   = idx_ok[l];
            pipe_d.s1_req[l].addr = idx_addr[l];
            pipe_d.s1_req[l].off  = idx_off[l];
        end
        pipe_d.s2_valid = pipe_q.s1_valid;
        for (int l = 0; l < LANES; l++) begin
            pipe_d.s2_dense[l] = pipe_q.s1_valid ? ext_dense[l] : '0;
            pipe_d.s2_pass[l]  = pipe_q.s1_valid && (ext_dense[l] != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < MEM_BYTES; a++) begin
                mem_q[a] <= 8'h00;
            end
        end else if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign out_valid_o = pipe_q.s2_valid;
    assign out_dense_o = pipe_q.s2_dense;
    assign out_pass_o  = pipe_q.s2_pass;
endmodule

// File: rtl/kv_filter_chk.sv
module kv_filter_chk #(
    parameter int LANES = 4,
    parameter int KEY_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [2:0]             cfg_width_i,
    input logic                   in_valid_i,
    input logic                   out_valid_o,
    input logic [LANES*KEY_W-1:0] out_dense_o,
    input logic [LANES-1:0]       out_pass_o
);
    AST_LAT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> ##1 out_valid_o); // R1
    AST_LAT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(in_valid_i, 2)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (out_pass_o == '0 && out_dense_o == '0)); // R12
    AST_RESERVED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && cfg_width_i > 3'd4) |=> ##1 (out_pass_o == '0)); // R9

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && cfg_width_i == 3'd0) |=> ##1 (out_dense_o[l*KEY_W +: KEY_W] < 2)); // R2
        AST_PAIR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && cfg_width_i == 3'd1) |=> ##1 (out_dense_o[l*KEY_W +: KEY_W] < 4)); // R3
        AST_NIBBLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && cfg_width_i == 3'd2) |=> ##1 (out_dense_o[l*KEY_W +: KEY_W] < 16)); // R4
        AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && cfg_width_i == 3'd3) |=> ##1 (out_dense_o[l*KEY_W +: KEY_W] < 256)); // R5
    end
endmodule

bind kv_filter kv_filter_chk #(
    .LANES (LANES),
    .KEY_W (KEY_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_width_i (cfg_width_i),
    .in_valid_i  (in_valid_i),
    .out_valid_o (out_valid_o),
    .out_dense_o (out_dense_o),
    .out_pass_o  (out_pass_o)
);

// File: tb/tb_kv_filter.sv
`timescale 1ns/1ps
module tb_kv_filter;
    localparam int LANES = 4, KEY_W = 32, SEG_BYTES = 16, NUM_SEGS = 8;
    localparam int MEM_BYTES = SEG_BYTES * NUM_SEGS;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   cfg_width_i = 3'd0;
    logic         in_valid_i = 1'b0;
    logic [127:0] in_keys_i = '0;
    logic         wr_en_i = 1'b0;
    logic [6:0]   wr_addr_i = '0;
    logic [7:0]   wr_data_i = '0;
    logic         out_valid_o;
    logic [127:0] out_dense_o;
    logic [3:0]   out_pass_o;

    kv_filter #(.LANES(LANES), .KEY_W(KEY_W), .SEG_BYTES(SEG_BYTES), .NUM_SEGS(NUM_SEGS)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_width_i(cfg_width_i), .in_valid_i(in_valid_i),
        .in_keys_i(in_keys_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .out_valid_o(out_valid_o), .out_dense_o(out_dense_o), .out_pass_o(out_pass_o));

    always #10 clk = ~clk;

    typedef struct {
        int           due;
        logic [127:0] dense;
        logic [3:0]   pass;
        int           req;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] model [MEM_BYTES];
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input int req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int shift_of(input logic [2:0] w);
        case (w)
            3'd0: return 7;
            3'd1: return 6;
            3'd2: return 5;
            3'd3: return 4;
            3'd4: return 2;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [2:0] w, input int seg, input int entry);
        return (32'(seg) << shift_of(w)) | 32'(entry);
    endfunction

    function automatic logic [31:0] ref_dense(input logic [31:0] key, input logic [2:0] w);
        int sh;
        int base;
        int e;
        logic [31:0] seg;
        sh = shift_of(w);
        if (sh < 0) return 32'd0;                        // R9
        seg = key >> sh;
        if (seg >= 32'(NUM_SEGS)) return 32'd0;          // R7
        e = int'(key & ((32'd1 << sh) - 32'd1));
        base = int'(seg) * SEG_BYTES;
        case (w)
            3'd0: return 32'((model[base + e / 8] >> (e % 8)) & 8'h01);
            3'd1: return 32'((model[base + e / 4] >> (2 * (e % 4))) & 8'h03);
            3'd2: return 32'((model[base + e / 2] >> (4 * (e % 2))) & 8'h0F);
            3'd3: return 32'(model[base + e]);
            default: return {model[base + 4*e + 3], model[base + 4*e + 2],
                             model[base + 4*e + 1], model[base + 4*e]};
        endcase
    endfunction

    task automatic push_exp(input logic [2:0] w, input logic [127:0] keys, input int req);
        exp_t x;
        x.due = cyc + 2;
        x.req = req;
        for (int l = 0; l < LANES; l++) begin
            x.dense[l*32 +: 32] = ref_dense(keys[l*32 +: 32], w);
            x.pass[l] = (x.dense[l*32 +: 32] != 32'd0);
        end
        sb_q.push_back(x);
    endtask

    task automatic beat(input logic [2:0] w, input logic [31:0] k0, input logic [31:0] k1,
                        input logic [31:0] k2, input logic [31:0] k3, input int req);
        @(negedge clk);
        wr_en_i = 1'b0;
        in_valid_i = 1'b1;
        cfg_width_i = w;
        in_keys_i = {k3, k2, k1, k0};
        push_exp(w, in_keys_i, req);
    endtask

    task automatic wr_byte(input int a, input logic [7:0] d);
        @(negedge clk);
        in_valid_i = 1'b0;
        wr_en_i = 1'b1;
        wr_addr_i = 7'(a);
        wr_data_i = d;
        model[a] = d;
    endtask

    task automatic wr_beat(input int a, input logic [7:0] d, input logic [2:0] w,
                           input logic [31:0] k0, input logic [31:0] k1,
                           input logic [31:0] k2, input logic [31:0] k3, input int req);
        @(negedge clk);
        wr_en_i = 1'b1;
        wr_addr_i = 7'(a);
        wr_data_i = d;
        model[a] = d;
        in_valid_i = 1'b1;
        cfg_width_i = w;
        in_keys_i = {k3, k2, k1, k0};
        push_exp(w, in_keys_i, req);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid_i = 1'b0;
            wr_en_i = 1'b0;
        end
    endtask

    // Scoreboard monitor: exact-cycle compare (R1), quiet outputs otherwise (R12)
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
                exp_t x;
                x = sb_q.pop_front();
                check(out_valid_o == 1'b1, 1, "result valid at two-cycle latency", 128'(out_valid_o), 128'd1);
                check(out_dense_o == x.dense, x.req, "dense keys", out_dense_o, x.dense);
                check(out_pass_o == x.pass, 8, "pass bits", 128'(out_pass_o), 128'(x.pass)); // R8
            end else begin
                check(out_valid_o == 1'b0, 1, "no spurious valid", 128'(out_valid_o), 128'd0);
                check(out_dense_o == '0 && out_pass_o == '0, 12, "idle outputs zero",
                      out_dense_o | 128'(out_pass_o), 128'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < MEM_BYTES; a++) model[a] = 8'h00;
        repeat (3) @(negedge clk);
        check(out_valid_o == 1'b0, 11, "valid low in reset", 128'(out_valid_o), 128'd0);
        rst_n = 1'b1;

        // R11: cleared table gives zero everywhere
        beat(3'd3, mk(3'd3,0,0), mk(3'd3,3,7), mk(3'd3,7,15), mk(3'd3,5,2), 11);
        beat(3'd4, mk(3'd4,0,0), mk(3'd4,2,3), mk(3'd4,6,1), mk(3'd4,7,2), 11);
        idle(3);

        for (int a = 0; a < MEM_BYTES; a++) wr_byte(a, 8'((a * 37 + 11) % 256) | 8'h01);
        idle(1);

        // R2: single bits, back to back
        beat(3'd0, mk(3'd0,0,0), mk(3'd0,3,77), mk(3'd0,7,127), mk(3'd0,5,9), 2);
        beat(3'd0, mk(3'd0,1,1), mk(3'd0,2,6), mk(3'd0,4,100), mk(3'd0,6,35), 2);
        // R3: bit pairs
        beat(3'd1, mk(3'd1,1,0), mk(3'd1,2,63), mk(3'd1,6,33), mk(3'd1,7,5), 3);
        idle(2);
        // R4: both halves of one byte
        beat(3'd2, mk(3'd2,4,10), mk(3'd2,4,11), mk(3'd2,0,31), mk(3'd2,7,0), 4);
        // R5: whole bytes
        beat(3'd3, mk(3'd3,2,3), mk(3'd3,7,15), mk(3'd3,0,0), mk(3'd3,5,8), 5);
        // R6: little-endian words
        beat(3'd4, mk(3'd4,0,0), mk(3'd4,1,3), mk(3'd4,7,2), mk(3'd4,4,1), 6);
        idle(1);
        // R7: segment past the end
        beat(3'd3, mk(3'd3,8,0), 32'hFFFF_FFFF, mk(3'd3,1,1), mk(3'd3,200,4), 7);
        beat(3'd0, mk(3'd0,8,0), mk(3'd4,8,0), mk(3'd0,7,3), 32'h8000_0000, 7);
        beat(3'd4, mk(3'd4,8,0), mk(3'd4,9,3), mk(3'd4,7,3), mk(3'd4,0,1), 7);
        // R9: reserved width codes
        beat(3'd5, 32'd0, 32'd17, 32'd40, 32'd100, 9);
        beat(3'd7, 32'd3, 32'd8, 32'd64, 32'd127, 9);
        idle(2);

        // R8: zero entries clear the pass bit
        wr_byte(2*16 + 3, 8'h00);
        wr_byte(4*16 + 0, 8'hF0);
        beat(3'd3, mk(3'd3,2,3), mk(3'd3,2,4), mk(3'd3,4,0), mk(3'd3,0,5), 8);
        beat(3'd2, mk(3'd2,4,0), mk(3'd2,4,1), mk(3'd2,2,6), mk(3'd2,2,7), 8);
        beat(3'd0, mk(3'd0,4,0), mk(3'd0,4,4), mk(3'd0,4,7), mk(3'd0,2,24), 8);
        idle(2);

        // R10: write on the same edge as the probe, then on the previous edge
        wr_beat(5*16 + 1, 8'hA5, 3'd3, mk(3'd3,5,1), mk(3'd3,5,0), mk(3'd3,5,2), mk(3'd3,6,1), 10);
        wr_byte(6*16 + 8, 8'h3C);
        beat(3'd3, mk(3'd3,6,8), mk(3'd3,5,1), mk(3'd3,6,8), mk(3'd3,0,0), 10);
        wr_byte(1*16 + 12, 8'h00);
        beat(3'd4, mk(3'd4,1,3), mk(3'd4,1,2), mk(3'd4,6,2), mk(3'd4,5,0), 10);
        idle(4);

        check(sb_q.size() == 0, 1, "all results delivered", 128'(sb_q.size()), 128'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule